// File: doc/BRIEF.md
# Rotated Immediate Encoder

This block decides whether a 32-bit constant can be written as an 8-bit field rotated right by an even number of bit positions. If it can, the block returns a 12-bit code that holds the 8-bit field and a 4-bit rotation count, and it raises a valid flag. If it cannot, valid stays low. An assembler-assist path or a code generator then knows that the constant has to be loaded from memory.

A caller places the constant on `value_i` and pulses `start_i` for one cycle. The block captures the constant and reports the result with a one-cycle `done_o` pulse. The result stays on `valid_o` and `enc_o` until the next result replaces it. The parameter `ITERATIVE` chooses between two search engines. The first tries one rotation per clock, beginning at rotation 0. The second tests all sixteen rotations in parallel within a single cycle. Both engines give the same code for every constant.

Top module: `rimm_encoder`

## Requirements
- R1: The code is split into fields: `enc_o[7:0]` holds the 8-bit field and `enc_o[11:8]` holds the rotation count n. When `valid_o` is 1, the field rotated right by 2n bits reproduces the captured constant exactly.
- R2: Every constant that is some 8-bit value rotated right by an even amount is reported with `valid_o`=1. Examples: 0xFF gives code 0x0FF, 0xFF00 gives 0xCFF, 0x8000 gives 0x902 and 0x104 gives 0xF41.
- R3: A constant that no even rotation can represent is reported with `valid_o`=0 and `enc_o`=0. Example: 0x101.
- R4: When several rotation counts work, the block reports the smallest one. The constant 0 encodes as 0x000, and the constant 0x4 encodes as 0x004 and not as 0xF01.
- R5: Count the clock edge that accepts `start_i` as edge 0. The iterative engine raises `done_o` after edge n+1, where n is the reported rotation count, or after edge 16 when the constant is not encodable. The parallel engine always raises it after edge 1.
- R6: `done_o` is high for exactly one cycle per accepted start. `valid_o` and `enc_o` change only in the cycle in which `done_o` rises.
- R7: A start pulse that arrives while a search is in progress is ignored. It neither changes the result nor produces an extra `done_o`.
- R8: A start pulse that arrives in the cycle in which `done_o` is high is accepted.
- R9: While reset is asserted and after it is released, `done_o`, `valid_o` and `enc_o` are 0 until the first result.
- R10: The iterative engine and the parallel engine give identical `valid_o` and `enc_o` for every constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that starts a search on `value_i` |
| value_i | input | 32 | Constant to encode, captured together with start |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| valid_o | output | 1 | 1 if the last constant was encodable |
| enc_o | output | 12 | Rotation count in [11:8] and 8-bit field in [7:0], or 0 |

## Verification
In the cycle in which `done_o` is high, the block also becomes able to accept a new start. Publishing one result and capturing the next constant can therefore happen on the same edge. The bench provokes this by driving a new start exactly in the `done_o` cycle of a finished search. It judges the overlap by checking that the second constant produces its own result with its own latency, counted from the edge that accepted it, and that the first result stays intact until then. A start issued in the middle of a long iterative search is also tested. It must be dropped, without stretching the search or adding a second pulse.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned ROT_W   = 4;
  localparam int unsigned ENC_W   = IMM_W + ROT_W;
  localparam int unsigned NUM_ROT = 1 << ROT_W;
endpackage

// File: rtl/rimm_rot_fit.sv
// Tests one candidate rotation count: rotate left by twice the count and
// check that nothing remains above the immediate field.
module rimm_rot_fit #(
  parameter int unsigned WORD_W = rimm_pkg::WORD_W,
  parameter int unsigned IMM_W  = rimm_pkg::IMM_W,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W
) (
  input  logic [WORD_W-1:0] value_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic              fit_o,
  output logic [IMM_W-1:0]  imm_o
);
  localparam int unsigned AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]    amt;
  logic [2*WORD_W-1:0] dbl;
  logic [WORD_W-1:0]   rotl;

  always_comb begin
    amt   = {rot_i, 1'b0};
    dbl   = {value_i, value_i} << amt;
    rotl  = dbl[2*WORD_W-1 -: WORD_W];
    fit_o = ~|rotl[WORD_W-1:IMM_W];
    imm_o = rotl[IMM_W-1:0];
  end
endmodule

// File: rtl/rimm_scan_all.sv
// Parallel search: one checker per rotation count, lowest count wins.
module rimm_scan_all #(
  parameter int unsigned WORD_W = rimm_pkg::WORD_W,
  parameter int unsigned IMM_W  = rimm_pkg::IMM_W,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W
) (
  input  logic [WORD_W-1:0] value_i,
  output logic              found_o,
  output logic [ROT_W-1:0]  rot_o,
  output logic [IMM_W-1:0]  imm_o
);
  localparam int unsigned NUM_ROT = 1 << ROT_W;

  logic [NUM_ROT-1:0] fit_vec;
  logic [IMM_W-1:0]   imm_arr [NUM_ROT];

  for (genvar g = 0; g < NUM_ROT; g++) begin : g_rot
    rimm_rot_fit #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_fit (
      .value_i (value_i),
      .rot_i   (ROT_W'(g)),
      .fit_o   (fit_vec[g]),
      .imm_o   (imm_arr[g])
    );
  end

  // Scan from the top so that the lowest fitting count is the last one assigned.
  always_comb begin
    found_o = 1'b0;
    rot_o   = '0;
    imm_o   = '0;
    for (int r = NUM_ROT - 1; r >= 0; r--) begin
      if (fit_vec[r]) begin
        found_o = 1'b1;
        rot_o   = ROT_W'(r);
        imm_o   = imm_arr[r];
      end
    end
  end
endmodule

// File: rtl/rimm_encoder.sv
module rimm_encoder #(
  parameter bit          ITERATIVE = 1'b1,
  parameter int unsigned WORD_W    = rimm_pkg::WORD_W,
  parameter int unsigned IMM_W     = rimm_pkg::IMM_W,
  parameter int unsigned ROT_W     = rimm_pkg::ROT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [WORD_W-1:0]        value_i,
  output logic                     done_o,
  output logic                     valid_o,
  output logic [IMM_W+ROT_W-1:0]   enc_o
);
  localparam int unsigned ENC_W    = IMM_W + ROT_W;
  localparam logic [ROT_W-1:0] LAST_ROT = '1;

  logic              busy_q, busy_d;
  logic [WORD_W-1:0] val_q;
  logic [ROT_W-1:0]  rot_q, rot_d;
  logic              done_q, done_d;
  logic              valid_q, valid_d;
  logic [ENC_W-1:0]  enc_q, enc_d;

  logic              accept;
  logic              fit;
  logic              last;
  logic [ROT_W-1:0]  cand_rot;
  logic [IMM_W-1:0]  cand_imm;

  if (ITERATIVE) begin : g_iter
    rimm_rot_fit #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_fit (
      .value_i (val_q),
      .rot_i   (rot_q),
      .fit_o   (fit),
      .imm_o   (cand_imm)
    );
    assign cand_rot = rot_q;
    assign last     = (rot_q == LAST_ROT);
  end else begin : g_par
    rimm_scan_all #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_scan (
      .value_i (val_q),
      .found_o (fit),
      .rot_o   (cand_rot),
      .imm_o   (cand_imm)
    );
    assign last = 1'b1;
  end

  assign accept = start_i & ~busy_q;

  // Next-state logic
  always_comb begin
    busy_d  = busy_q;
    rot_d   = rot_q;
    done_d  = 1'b0;
    valid_d = valid_q;
    enc_d   = enc_q;
    if (busy_q) begin
      if (fit || last) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        valid_d = fit;
        enc_d   = fit ? {cand_rot, cand_imm} : '0;
      end else begin
        rot_d = rot_q + 1'b1;
      end
    end else if (accept) begin
      busy_d = 1'b1;
      rot_d  = '0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rot_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      enc_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      rot_q   <= rot_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      enc_q   <= enc_d;
    end
  end

  // Operand register, loaded only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (accept) begin
      val_q <= value_i;
    end
  end

  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign enc_o   = enc_q;
endmodule

// File: rtl/rimm_encoder_sva.sv
module rimm_encoder_sva #(
  parameter bit          ITERATIVE = 1'b1,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IMM_W     = 8,
  parameter int unsigned ROT_W     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [WORD_W-1:0]      value_i,
  input logic                   busy,
  input logic                   done_o,
  input logic                   valid_o,
  input logic [IMM_W+ROT_W-1:0] enc_o
);
  localparam int unsigned NUM_ROT = 1 << ROT_W;
  localparam int unsigned MAX_LAT = ITERATIVE ? NUM_ROT : 1;

  logic [WORD_W-1:0] cap_q;
  logic [7:0]        cyc_q;

  // Shadow copy of the accepted constant and edges elapsed since acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      cyc_q <= '0;
    end else if (start_i && !busy) begin
      cap_q <= value_i;
      cyc_q <= 8'd1;
    end else if (busy && cyc_q != 8'hFF) begin
      cyc_q <= cyc_q + 8'd1;
    end
  end

  function automatic logic [WORD_W-1:0] expand(input logic [IMM_W+ROT_W-1:0] code);
    logic [2*WORD_W-1:0] d;
    logic [WORD_W-1:0]   f;
    f = WORD_W'(code[IMM_W-1:0]);
    d = {f, f} >> {code[IMM_W+ROT_W-1:IMM_W], 1'b0};
    return d[WORD_W-1:0];
  endfunction

  p_roundtrip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (expand(enc_o) == cap_q));

  p_zero_on_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (enc_o == '0));

  p_latency_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q >= 8'd2 && cyc_q <= 8'(MAX_LAT + 1)));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(enc_o) && $stable(valid_o)));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy);
endmodule

bind rimm_encoder rimm_encoder_sva #(
  .ITERATIVE (ITERATIVE),
  .WORD_W    (WORD_W),
  .IMM_W     (IMM_W),
  .ROT_W     (ROT_W)
) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .value_i (value_i),
  .busy    (busy_q),
  .done_o  (done_o),
  .valid_o (valid_o),
  .enc_o   (enc_o)
);

// File: tb/rimm_encoder_tb.sv
`timescale 1ns/1ps
module rimm_encoder_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] value;
  logic        done_i, valid_i, done_c, valid_c;
  logic [11:0] enc_i, enc_c;
  int          n_chk;
  int          n_fail;

  rimm_encoder #(.ITERATIVE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .value_i(value),
    .done_o(done_i), .valid_o(valid_i), .enc_o(enc_i));

  rimm_encoder #(.ITERATIVE(1'b0)) u_dut_par (
    .clk(clk), .rst_n(rst_n), .start_i(start), .value_i(value),
    .done_o(done_c), .valid_o(valid_c), .enc_o(enc_c));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Model built from the requirements: smallest even right-rotation of an 8-bit field.
  task automatic model(input logic [31:0] v, output bit ok, output logic [11:0] code, output int lat);
    ok = 1'b0; code = '0; lat = 16;
    for (int r = 15; r >= 0; r--) begin
      logic [31:0] f;
      f = (v << (2 * r)) | (r == 0 ? 32'h0 : (v >> (32 - 2 * r)));
      if (f[31:8] == 24'h0) begin
        ok = 1'b1; code = {4'(r), f[7:0]}; lat = r + 1;
      end
    end
  endtask

  function automatic logic [31:0] decode(input logic [11:0] code);
    int          s;
    logic [31:0] f;
    s = 2 * int'(code[11:8]);
    f = {24'h0, code[7:0]};
    return (s == 0) ? f : ((f >> s) | (f << (32 - s)));
  endfunction

  // Waits for both engines to report after an accepted start, then checks everything.
  task automatic collect(input logic [31:0] v, input string tag);
    bit          ok;
    logic [11:0] code;
    int          lat;
    int          li, lc;
    bit          vi, vc;
    logic [11:0] ei, ec;
    model(v, ok, code, lat);
    li = 0; lc = 0; vi = 0; vc = 0; ei = '0; ec = '0;
    for (int k = 1; k <= 20 && (li == 0 || lc == 0); k++) begin
      @(negedge clk);
      if (done_i && li == 0) begin li = k; vi = valid_i; ei = enc_i; end
      if (done_c && lc == 0) begin lc = k; vc = valid_c; ec = enc_c; end
    end
    chk(vi == ok, {"R2/R3 valid ", tag}, 32'(vi), 32'(ok));
    chk(ei == code, {"R4 code ", tag}, 32'(ei), 32'(code));
    chk(li == lat, {"R5 iterative latency ", tag}, 32'(li), 32'(lat));
    chk(lc == 1, {"R5 parallel latency ", tag}, 32'(lc), 32'd1);
    chk(vc == vi && ec == ei, {"R10 engines agree ", tag}, {19'h0, vc, ec}, {19'h0, vi, ei});
    if (vi) chk(decode(ei) == v, {"R1 round trip ", tag}, decode(ei), v);
    if (!vi) chk(ei == 12'h0, {"R3 zero code ", tag}, 32'(ei), 32'h0);
    @(negedge clk);
    chk(!done_i && !done_c, {"R6 single pulse ", tag}, {30'h0, done_i, done_c}, 32'h0);
    chk(valid_i == vi && enc_i == ei, {"R6 hold ", tag}, {19'h0, valid_i, enc_i}, {19'h0, vi, ei});
  endtask

  task automatic launch(input logic [31:0] v);
    @(negedge clk);
    value = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk(!done_i && !valid_i && enc_i == 12'h0, "R9 reset iterative", {19'h0, valid_i, enc_i}, 32'h0);
    chk(!done_c && !valid_c && enc_c == 12'h0, "R9 reset parallel", {19'h0, valid_c, enc_c}, 32'h0);
  endtask

  task automatic t_known;
    launch(32'h0000_00FF); collect(32'h0000_00FF, "R2 0xFF");
    chk(enc_i == 12'h0FF, "R2 0xFF code", 32'(enc_i), 32'h0FF);
    launch(32'h0000_FF00); collect(32'h0000_FF00, "R2 0xFF00");
    chk(enc_i == 12'hCFF, "R2 0xFF00 code", 32'(enc_i), 32'hCFF);
    launch(32'h0000_8000); collect(32'h0000_8000, "R2 0x8000");
    chk(enc_i == 12'h902, "R2 0x8000 code", 32'(enc_i), 32'h902);
    launch(32'h0000_0104); collect(32'h0000_0104, "R2 0x104");
    chk(enc_i == 12'hF41, "R2 0x104 code", 32'(enc_i), 32'hF41);
    launch(32'h0000_0101); collect(32'h0000_0101, "R3 0x101");
    chk(!valid_i && enc_i == 12'h0, "R3 0x101 reject", {19'h0, valid_i, enc_i}, 32'h0);
  endtask

  task automatic t_smallest;
    launch(32'h0); collect(32'h0, "R4 zero");
    chk(valid_i && enc_i == 12'h000, "R4 zero code", {19'h0, valid_i, enc_i}, 32'h1000);
    launch(32'h4); collect(32'h4, "R4 0x4");
    chk(enc_i == 12'h004, "R4 0x4 code", 32'(enc_i), 32'h004);
    launch(32'hF000_000F); collect(32'hF000_000F, "R4 wrap");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      logic [31:0] b;
      int          s;
      if (i % 2 == 0) begin
        b = 32'((i * 37 + 5) & 255);
        s = (i * 7) % 32;
        v = (s == 0) ? b : ((b >> s) | (b << (32 - s)));
      end else begin
        v = 32'(i) * 32'h9E37_79B9;
      end
      launch(v);
      collect(v, "R10 sweep");
    end
  endtask

  task automatic t_busy_ignore;
    int li;
    launch(32'h0000_0101);
    li = 0;
    for (int k = 1; k <= 24; k++) begin
      if (k == 3) begin value = 32'h0000_00FF; start = 1'b1; end
      if (k == 4) start = 1'b0;
      @(negedge clk);
      if (done_i) begin
        if (li == 0) li = k;
        else chk(1'b0, "R7 extra done", 32'(k), 32'(li));
      end
    end
    chk(li == 16, "R7 latency unchanged", 32'(li), 32'd16);
    chk(!valid_i && enc_i == 12'h0, "R7 result unchanged", {19'h0, valid_i, enc_i}, 32'h0);
  endtask

  task automatic t_back_to_back;
    launch(32'h0000_00FF);
    @(negedge clk);
    chk(done_i && done_c && enc_i == 12'h0FF, "R8 first done", {19'h0, done_i, enc_i}, 32'h10FF);
    value = 32'h0000_0104; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(enc_i == 12'h0FF, "R8 first result held", 32'(enc_i), 32'h0FF);
    collect(32'h0000_0104, "R8 second start");
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    start = 1'b0; value = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_known;
    t_smallest;
    t_busy_ignore;
    t_back_to_back;
    t_sweep;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule